// File: doc/BRIEF.md
# Power-Cap Mailbox Command Engine

This block serves a host through a small byte-wide mailbox. The host fills a command record: a flag byte, a request ID, a command code, a 16-bit length and a 16-bit argument. It then sets the command flag to the ready code. A periodic tick strobe starts each poll. On a qualifying poll the engine first marks the response as in progress and then, on a later poll, runs the command. It fills the response record, publishes a ready flag, frees the command slot and pulses a message-interrupt request.

The one command the engine carries out sets a power cap, and it checks the length of that command. A zero request removes the cap. A nonzero request is clamped to the configured range. The engine keeps the cap state: the cap kind, the current value and the fixed hard minimum, soft minimum and maximum. It also holds a constant activity state byte. All of this is readable through the same byte port.

Byte map (hexadecimal addresses; 16-bit fields are big-endian, high byte at the lower address):

| Area | Byte addresses |
|------|----------------|
| Command record, host-writable | flag 00, ID 01, code 02, length 03/04, argument 05/06 |
| Response record | flag 08 (host-writable), ID 09, code 0A, status 0B, length 0C/0D, data 0E/0F |
| Status and cap state, read-only | state 10, cap kind 11, current cap 12/13, hard minimum 14/15, soft minimum 16/17, maximum 18/19 |

Every other address reads 0.

Top module: `pcap_mbox_engine`

## Requirements
- R1: After reset, both flag bytes, the response fields and the cap kind read 0. The state byte reads 0x03. Current cap and maximum read 100, hard minimum reads 10, soft minimum reads 20, and the interrupt output is low.
- R2: No response byte changes unless a tick arrives while the command flag is exactly 0x80. A flag of 0x81, or 0x80 held without a tick, leaves the response record untouched.
- R3: A qualifying tick with response flag 0x00 sets the response flag to 0x02 on the next cycle. No other field changes, the command flag stays 0x80 and no interrupt is raised.
- R4: A qualifying tick with a response flag other than 0x00 and 0x02 completes at once with status 0x15 and length 0.
- R5: For command code 0xD1, a length other than 2 gives status 0x12 and length 2, with data equal to the current cap. The cap is unchanged.
- R6: Command 0xD1 with length 2 and argument 0 sets cap kind 0x00 and current cap 100. The response has status 0x00, length 2 and data 100.
- R7: Command 0xD1 with length 2 and a nonzero argument sets cap kind 0x02 and current cap to the argument clamped to 10..100. The response has status 0x00, length 2 and the clamped value as data.
- R8: Any command code other than 0xD1 completes with status 0x11, length 0 and data 0.
- R9: The response ID and code echo the command's. The response fields settle one cycle after the executing tick's edge. One cycle after that, the response flag reads 0x01 and the command flag 0x00, and the interrupt output is high for exactly that one cycle. A tick during that publish cycle is ignored.
- R10: 16-bit fields are big-endian. A length written as bytes 00,02 is the value 2, and an argument written as bytes 01,00 is the value 256.
- R11: Host writes to read-only addresses (09..0F and 10..19) have no effect. An engine update to a flag byte wins over a host write to it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Poll strobe, one cycle per poll |
| hst_we_i | input | 1 | Host byte write enable |
| hst_waddr_i | input | ADDR_W | Host write byte address |
| hst_wdata_i | input | 8 | Host write byte |
| hst_raddr_i | input | ADDR_W | Host read byte address |
| hst_rdata_o | output | 8 | Read byte for hst_raddr_i, combinational |
| msg_irq_o | output | 1 | One-cycle message-interrupt request on completion |

## Verification
A wrong sequencer state shows up at the response flag byte. If the in-progress step is skipped or repeated, byte 08 differs on the cycle after the first qualifying tick. If the publish step is skipped or repeated, byte 08, the command flag or the interrupt differs one cycle after the fields load. A wrong cap register or a wrong clamp shows in the response data and at bytes 12/13 on the cycle after the executing tick. It then persists, and it reappears as the returned data of any later length-error response.

// File: rtl/pcap_mbox_pkg.sv
package pcap_mbox_pkg;

   localparam int FIELD_W = 16;

   // flag byte codes (host-visible protocol)
   localparam logic [7:0] FLG_IDLE      = 8'h00;
   localparam logic [7:0] FLG_DONE      = 8'h01;
   localparam logic [7:0] FLG_BUSY      = 8'h02;
   localparam logic [7:0] FLG_CMD_READY = 8'h80;

   // completion status codes
   localparam logic [7:0] ST_OK       = 8'h00;
   localparam logic [7:0] ST_BAD_CODE = 8'h11;
   localparam logic [7:0] ST_BAD_LEN  = 8'h12;
   localparam logic [7:0] ST_FAULT    = 8'h15;

   // cap kinds
   localparam logic [7:0] CAP_KIND_NONE = 8'h00;
   localparam logic [7:0] CAP_KIND_HOST = 8'h02;

   // byte map
   localparam int AD_C_FLAG  = 0;
   localparam int AD_C_ID    = 1;
   localparam int AD_C_CODE  = 2;
   localparam int AD_C_LEN_H = 3;
   localparam int AD_C_LEN_L = 4;
   localparam int AD_C_ARG_H = 5;
   localparam int AD_C_ARG_L = 6;
   localparam int AD_R_FLAG  = 8;
   localparam int AD_R_ID    = 9;
   localparam int AD_R_CODE  = 10;
   localparam int AD_R_STAT  = 11;
   localparam int AD_R_LEN_H = 12;
   localparam int AD_R_LEN_L = 13;
   localparam int AD_R_DAT_H = 14;
   localparam int AD_R_DAT_L = 15;
   localparam int AD_STATE   = 16;
   localparam int AD_KIND    = 17;
   localparam int AD_CUR_H   = 18;
   localparam int AD_CUR_L   = 19;
   localparam int AD_HARD_H  = 20;
   localparam int AD_HARD_L  = 21;
   localparam int AD_SOFT_H  = 22;
   localparam int AD_SOFT_L  = 23;
   localparam int AD_MAX_H   = 24;
   localparam int AD_MAX_L   = 25;
   localparam int MAP_TOP    = 26;
   localparam int CMD_BYTES  = 7;

   typedef struct packed {
      logic [7:0]         flag;
      logic [7:0]         id;
      logic [7:0]         code;
      logic [FIELD_W-1:0] len;
      logic [FIELD_W-1:0] arg;
   } mb_cmd_t;

   typedef struct packed {
      logic [7:0]         status;
      logic [FIELD_W-1:0] len;
      logic [FIELD_W-1:0] data;
      logic               cap_we;
      logic [7:0]         cap_kind;
      logic [FIELD_W-1:0] cap_val;
   } mb_result_t;

   typedef enum logic {
      SEQ_IDLE    = 1'b0,
      SEQ_PUBLISH = 1'b1
   } seq_state_t;

endpackage

// File: rtl/mbox_cmd_regs.sv
module mbox_cmd_regs
   import pcap_mbox_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int BASE   = AD_C_FLAG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              flag_clr,
   output mb_cmd_t           cmd_o
);

   localparam int NB = CMD_BYTES;

   logic [NB-1:0] hit;
   logic [7:0]    byte_q [NB];

   for (genvar gi = 0; gi < NB; gi++) begin : g_hit
      assign hit[gi] = wr_en && (wr_addr == ADDR_W'(BASE + gi));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NB; i++) byte_q[i] <= '0;
      end else begin
         for (int i = 0; i < NB; i++) begin
            if (hit[i]) byte_q[i] <= wr_data;
         end
         // engine release of the slot wins over a host write
         if (flag_clr) byte_q[0] <= FLG_IDLE;
      end
   end

   assign cmd_o = {byte_q[0], byte_q[1], byte_q[2], byte_q[3],
                   byte_q[4], byte_q[5], byte_q[6]};

   // R9 / R11: slot release lands on the next cycle even under a host write
   p_flag_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> (cmd_o.flag == FLG_IDLE));

endmodule

// File: rtl/pcap_cmd_decode.sv
module pcap_cmd_decode
   import pcap_mbox_pkg::*;
#(
   parameter int         CAP_MAX_W      = 100,
   parameter int         CAP_HARD_MIN_W = 10,
   parameter logic [7:0] SET_CAP_CODE   = 8'hD1
) (
   input  logic [7:0]         rsp_flag_i,
   input  logic [7:0]         code_i,
   input  logic [FIELD_W-1:0] len_i,
   input  logic [FIELD_W-1:0] arg_i,
   input  logic [FIELD_W-1:0] cap_now_i,
   output mb_result_t         res_o
);

   localparam logic [FIELD_W-1:0] MAXV     = FIELD_W'(CAP_MAX_W);
   localparam logic [FIELD_W-1:0] MINV     = FIELD_W'(CAP_HARD_MIN_W);
   localparam logic [FIELD_W-1:0] WORD_LEN = FIELD_W'(2);

   logic [FIELD_W-1:0] clamped;

   always_comb begin
      if (arg_i < MINV)      clamped = MINV;
      else if (arg_i > MAXV) clamped = MAXV;
      else                   clamped = arg_i;
   end

   always_comb begin
      res_o          = '0;
      res_o.cap_kind = CAP_KIND_NONE;
      res_o.cap_val  = cap_now_i;
      if (rsp_flag_i != FLG_BUSY) begin
         res_o.status = ST_FAULT;
      end else if (code_i != SET_CAP_CODE) begin
         res_o.status = ST_BAD_CODE;
      end else if (len_i != WORD_LEN) begin
         res_o.status = ST_BAD_LEN;
         res_o.len    = WORD_LEN;
         res_o.data   = cap_now_i;
      end else if (arg_i == '0) begin
         res_o.status   = ST_OK;
         res_o.len      = WORD_LEN;
         res_o.data     = MAXV;
         res_o.cap_we   = 1'b1;
         res_o.cap_kind = CAP_KIND_NONE;
         res_o.cap_val  = MAXV;
      end else begin
         res_o.status   = ST_OK;
         res_o.len      = WORD_LEN;
         res_o.data     = clamped;
         res_o.cap_we   = 1'b1;
         res_o.cap_kind = CAP_KIND_HOST;
         res_o.cap_val  = clamped;
      end
   end

   // R7: a written cap value never leaves the legal range
   always_comb begin
      if (res_o.cap_we) begin
         a_cap_in_range_r7: assert (res_o.cap_val >= MINV && res_o.cap_val <= MAXV);
      end
   end

endmodule

// File: rtl/pcap_sequencer.sv
module pcap_sequencer
   import pcap_mbox_pkg::*;
#(
   parameter int CAP_MAX_W      = 100,
   parameter int CAP_HARD_MIN_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic [7:0]         cmd_flag_i,
   input  logic [7:0]         cmd_id_i,
   input  logic [7:0]         cmd_code_i,
   input  mb_result_t         res_i,
   input  logic               host_flag_we_i,
   input  logic [7:0]         host_flag_d_i,
   output logic [7:0]         rsp_flag_o,
   output logic [7:0]         rsp_id_o,
   output logic [7:0]         rsp_code_o,
   output logic [7:0]         rsp_stat_o,
   output logic [FIELD_W-1:0] rsp_len_o,
   output logic [FIELD_W-1:0] rsp_data_o,
   output logic [7:0]         cap_kind_o,
   output logic [FIELD_W-1:0] cap_cur_o,
   output logic               cmd_clr_o,
   output logic               irq_o
);

   localparam logic [FIELD_W-1:0] MAXV = FIELD_W'(CAP_MAX_W);
   localparam logic [FIELD_W-1:0] MINV = FIELD_W'(CAP_HARD_MIN_W);

   seq_state_t st_q;
   logic       fire;
   logic       first_poll;

   assign fire       = (st_q == SEQ_IDLE) && tick_i && (cmd_flag_i == FLG_CMD_READY);
   assign first_poll = (rsp_flag_o == FLG_IDLE);
   assign cmd_clr_o  = (st_q == SEQ_PUBLISH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SEQ_IDLE;
         rsp_flag_o <= FLG_IDLE;
         rsp_id_o   <= '0;
         rsp_code_o <= '0;
         rsp_stat_o <= '0;
         rsp_len_o  <= '0;
         rsp_data_o <= '0;
         cap_kind_o <= CAP_KIND_NONE;
         cap_cur_o  <= MAXV;
         irq_o      <= 1'b0;
      end else begin
         irq_o <= (st_q == SEQ_PUBLISH);
         if (host_flag_we_i) rsp_flag_o <= host_flag_d_i;
         unique case (st_q)
            SEQ_IDLE: begin
               if (fire) begin
                  if (first_poll) begin
                     rsp_flag_o <= FLG_BUSY;
                  end else begin
                     rsp_id_o   <= cmd_id_i;
                     rsp_code_o <= cmd_code_i;
                     rsp_stat_o <= res_i.status;
                     rsp_len_o  <= res_i.len;
                     rsp_data_o <= res_i.data;
                     if (res_i.cap_we) begin
                        cap_kind_o <= res_i.cap_kind;
                        cap_cur_o  <= res_i.cap_val;
                     end
                     st_q <= SEQ_PUBLISH;
                  end
               end
            end
            SEQ_PUBLISH: begin
               rsp_flag_o <= FLG_DONE;
               st_q       <= SEQ_IDLE;
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   // R3: first poll only marks the response busy
   p_busy_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && first_poll) |=> (rsp_flag_o == FLG_BUSY && !irq_o && st_q == SEQ_IDLE));

   // R2: without a qualifying poll the response record holds
   p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_IDLE && !fire) |=>
         ($stable(rsp_stat_o) && $stable(rsp_len_o) && $stable(rsp_data_o) && $stable(cap_cur_o)));

   // R4: unexpected response flag completes with the fault status
   p_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && rsp_flag_o != FLG_IDLE && rsp_flag_o != FLG_BUSY) |=>
         (rsp_stat_o == ST_FAULT && rsp_len_o == '0 && st_q == SEQ_PUBLISH));

   // R9: publish raises the ready flag together with the interrupt
   p_publish_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_PUBLISH) |=> (rsp_flag_o == FLG_DONE && irq_o && st_q == SEQ_IDLE));

   // R9: interrupt request is a single-cycle pulse
   p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R7: stored cap stays within the hard minimum and maximum
   p_cap_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_cur_o >= MINV && cap_cur_o <= MAXV));

endmodule

// File: rtl/pcap_mbox_engine.sv
module pcap_mbox_engine
   import pcap_mbox_pkg::*;
#(
   parameter int         ADDR_W         = 5,
   parameter int         CAP_MAX_W      = 100,
   parameter int         CAP_HARD_MIN_W = 10,
   parameter int         CAP_SOFT_MIN_W = 20,
   parameter logic [7:0] SET_CAP_CODE   = 8'hD1,
   parameter logic [7:0] ACTIVE_STATE   = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              hst_we_i,
   input  logic [ADDR_W-1:0] hst_waddr_i,
   input  logic [7:0]        hst_wdata_i,
   input  logic [ADDR_W-1:0] hst_raddr_i,
   output logic [7:0]        hst_rdata_o,
   output logic              msg_irq_o
);

   localparam logic [FIELD_W-1:0] MAXV  = FIELD_W'(CAP_MAX_W);
   localparam logic [FIELD_W-1:0] HARDV = FIELD_W'(CAP_HARD_MIN_W);
   localparam logic [FIELD_W-1:0] SOFTV = FIELD_W'(CAP_SOFT_MIN_W);

   initial begin
      a_addr_fits: assert ((1 << ADDR_W) >= MAP_TOP)
         else $error("ADDR_W too small for the mailbox map");
      a_limit_order: assert (CAP_HARD_MIN_W > 0 && CAP_HARD_MIN_W <= CAP_SOFT_MIN_W &&
                             CAP_SOFT_MIN_W <= CAP_MAX_W && CAP_MAX_W < (1 << FIELD_W))
         else $error("cap limits out of order");
   end

   mb_cmd_t            cmd;
   mb_result_t         res;
   logic               cmd_clr;
   logic               host_flag_we;
   logic [7:0]         rsp_flag, rsp_id, rsp_code, rsp_stat, cap_kind;
   logic [FIELD_W-1:0] rsp_len, rsp_data, cap_cur;

   assign host_flag_we = hst_we_i && (hst_waddr_i == ADDR_W'(AD_R_FLAG));

   mbox_cmd_regs #(.ADDR_W(ADDR_W), .BASE(AD_C_FLAG)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (hst_we_i),
      .wr_addr  (hst_waddr_i),
      .wr_data  (hst_wdata_i),
      .flag_clr (cmd_clr),
      .cmd_o    (cmd)
   );

   pcap_cmd_decode #(
      .CAP_MAX_W      (CAP_MAX_W),
      .CAP_HARD_MIN_W (CAP_HARD_MIN_W),
      .SET_CAP_CODE   (SET_CAP_CODE)
   ) u_dec (
      .rsp_flag_i (rsp_flag),
      .code_i     (cmd.code),
      .len_i      (cmd.len),
      .arg_i      (cmd.arg),
      .cap_now_i  (cap_cur),
      .res_o      (res)
   );

   pcap_sequencer #(
      .CAP_MAX_W      (CAP_MAX_W),
      .CAP_HARD_MIN_W (CAP_HARD_MIN_W)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick_i         (tick_i),
      .cmd_flag_i     (cmd.flag),
      .cmd_id_i       (cmd.id),
      .cmd_code_i     (cmd.code),
      .res_i          (res),
      .host_flag_we_i (host_flag_we),
      .host_flag_d_i  (hst_wdata_i),
      .rsp_flag_o     (rsp_flag),
      .rsp_id_o       (rsp_id),
      .rsp_code_o     (rsp_code),
      .rsp_stat_o     (rsp_stat),
      .rsp_len_o      (rsp_len),
      .rsp_data_o     (rsp_data),
      .cap_kind_o     (cap_kind),
      .cap_cur_o      (cap_cur),
      .cmd_clr_o      (cmd_clr),
      .irq_o          (msg_irq_o)
   );

   always_comb begin
      hst_rdata_o = '0;
      case (hst_raddr_i)
         ADDR_W'(AD_C_FLAG):  hst_rdata_o = cmd.flag;
         ADDR_W'(AD_C_ID):    hst_rdata_o = cmd.id;
         ADDR_W'(AD_C_CODE):  hst_rdata_o = cmd.code;
         ADDR_W'(AD_C_LEN_H): hst_rdata_o = cmd.len[15:8];
         ADDR_W'(AD_C_LEN_L): hst_rdata_o = cmd.len[7:0];
         ADDR_W'(AD_C_ARG_H): hst_rdata_o = cmd.arg[15:8];
         ADDR_W'(AD_C_ARG_L): hst_rdata_o = cmd.arg[7:0];
         ADDR_W'(AD_R_FLAG):  hst_rdata_o = rsp_flag;
         ADDR_W'(AD_R_ID):    hst_rdata_o = rsp_id;
         ADDR_W'(AD_R_CODE):  hst_rdata_o = rsp_code;
         ADDR_W'(AD_R_STAT):  hst_rdata_o = rsp_stat;
         ADDR_W'(AD_R_LEN_H): hst_rdata_o = rsp_len[15:8];
         ADDR_W'(AD_R_LEN_L): hst_rdata_o = rsp_len[7:0];
         ADDR_W'(AD_R_DAT_H): hst_rdata_o = rsp_data[15:8];
         ADDR_W'(AD_R_DAT_L): hst_rdata_o = rsp_data[7:0];
         ADDR_W'(AD_STATE):   hst_rdata_o = ACTIVE_STATE;
         ADDR_W'(AD_KIND):    hst_rdata_o = cap_kind;
         ADDR_W'(AD_CUR_H):   hst_rdata_o = cap_cur[15:8];
         ADDR_W'(AD_CUR_L):   hst_rdata_o = cap_cur[7:0];
         ADDR_W'(AD_HARD_H):  hst_rdata_o = HARDV[15:8];
         ADDR_W'(AD_HARD_L):  hst_rdata_o = HARDV[7:0];
         ADDR_W'(AD_SOFT_H):  hst_rdata_o = SOFTV[15:8];
         ADDR_W'(AD_SOFT_L):  hst_rdata_o = SOFTV[7:0];
         ADDR_W'(AD_MAX_H):   hst_rdata_o = MAXV[15:8];
         ADDR_W'(AD_MAX_L):   hst_rdata_o = MAXV[7:0];
         default:             hst_rdata_o = '0;
      endcase
   end

endmodule

// File: tb/test_pcap_mbox_engine.sv
module test_pcap_mbox_engine;

   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] waddr = '0;
   logic [7:0]    wdata = '0;
   logic [AW-1:0] raddr = '0;
   logic [7:0]    rdata;
   logic          irq;

   always #5 clk = ~clk;

   pcap_mbox_engine i_pcap_mbox_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .hst_we_i    (we),
      .hst_waddr_i (waddr),
      .hst_wdata_i (wdata),
      .hst_raddr_i (raddr),
      .hst_rdata_o (rdata),
      .msg_irq_o   (irq)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int sweep = 0;

   // ---------------- behavioural reference model ----------------
   int m [32];
   int o [32];
   int m_irq = 0;
   int m_pend = 0;
   int len_v, arg_v, cur_v, st_v, ln_v, dv_v, kind_v;

   function automatic bit host_writable(int a);
      return (a <= 6) || (a == 8);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 32; i++) m[i] = 0;
      m[16] = 3; m[19] = 100; m[21] = 10; m[23] = 20; m[25] = 100;
      m_irq = 0; m_pend = 0;
   endtask

   initial model_reset();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         for (int i = 0; i < 32; i++) o[i] = m[i];
         m_irq = m_pend;
         if (we && host_writable(int'(waddr))) m[int'(waddr)] = int'(wdata);
         if (m_pend != 0) begin
            m[8] = 1; m[0] = 0; m_pend = 0;
         end else if (tick && o[0] == 'h80) begin
            if (o[8] == 0) begin
               m[8] = 2;
            end else begin
               len_v = o[3] * 256 + o[4];
               arg_v = o[5] * 256 + o[6];
               cur_v = o[18] * 256 + o[19];
               kind_v = o[17];
               if (o[8] != 2) begin
                  st_v = 'h15; ln_v = 0; dv_v = 0;
               end else if (o[2] != 'hD1) begin
                  st_v = 'h11; ln_v = 0; dv_v = 0;
               end else if (len_v != 2) begin
                  st_v = 'h12; ln_v = 2; dv_v = cur_v;
               end else if (arg_v == 0) begin
                  st_v = 0; ln_v = 2; cur_v = 100; kind_v = 0; dv_v = 100;
               end else begin
                  cur_v = (arg_v < 10) ? 10 : (arg_v > 100) ? 100 : arg_v;
                  st_v = 0; ln_v = 2; kind_v = 2; dv_v = cur_v;
               end
               m[9] = o[1]; m[10] = o[2]; m[11] = st_v;
               m[12] = ln_v / 256; m[13] = ln_v % 256;
               m[14] = dv_v / 256; m[15] = dv_v % 256;
               m[17] = kind_v; m[18] = cur_v / 256; m[19] = cur_v % 256;
               m_pend = 1;
            end
         end
      end
   end

   function automatic string tag_of(int a);
      if (a < 8)  return "R11";
      if (a < 16) return "R9";
      return "R7";
   endfunction

   // ---------------- checking helpers ----------------
   task automatic check(string tag, int act, int exp, string what);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // one clock: compare against the model, then drive inputs for the next edge
   task automatic cyc(bit w, int a, int d, bit t);
      @(negedge clk);
      check(tag_of(int'(raddr)), int'(rdata), m[int'(raddr)], $sformatf("model byte %0d", raddr));
      check("R9", int'(irq), m_irq, "model irq");
      we = w; waddr = AW'(a); wdata = 8'(d); tick = t;
      raddr = AW'(sweep);
      sweep = (sweep + 1) % 26;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
   endtask

   task automatic wr(int a, int d);
      cyc(1, a, d, 0);
   endtask

   task automatic peek(int a, int exp, string tag);
      raddr = AW'(a);
      #1;
      check(tag, int'(rdata), exp, $sformatf("byte %0d", a));
   endtask

   task automatic load_cmd(int id, int code, int len, int arg, int flag);
      wr(1, id); wr(2, code);
      wr(3, len / 256); wr(4, len % 256);
      wr(5, arg / 256); wr(6, arg % 256);
      wr(0, flag);
   endtask

   // full handshake from response flag 0: busy poll, then executing poll
   task automatic run_full();
      cyc(0, 0, 0, 1);
      idle(1);
      peek(8, 'h02, "R3");
      peek(0, 'h80, "R3");
      check("R3", int'(irq), 0, "irq on busy step");
      cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 1);             // tick in publish cycle, ignored
      peek(8, 'h02, "R9");         // fields loaded, flag not yet ready
      check("R9", int'(irq), 0, "irq before publish");
      idle(1);
      peek(8, 'h01, "R9");
      peek(0, 'h00, "R9");
      check("R9", int'(irq), 1, "irq at publish");
      idle(1);
      check("R9", int'(irq), 0, "irq after pulse");
   endtask

   task automatic expect_rsp(int st, int ln, int dv, string tag);
      peek(11, st, tag);
      peek(12, ln / 256, tag); peek(13, ln % 256, tag);
      peek(14, dv / 256, tag); peek(15, dv % 256, tag);
   endtask

   task automatic set_cap(int arg, int exp_cur, int exp_kind, string tag);
      wr(8, 0);
      load_cmd('h20, 'hD1, 2, arg, 'h80);
      run_full();
      expect_rsp(0, 2, exp_cur, tag);
      peek(17, exp_kind, tag);
      peek(18, exp_cur / 256, tag); peek(19, exp_cur % 256, tag);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      peek(0, 0, "R1"); peek(8, 0, "R1"); peek(11, 0, "R1"); peek(17, 0, "R1");
      peek(16, 3, "R1"); peek(19, 100, "R1"); peek(21, 10, "R1");
      peek(23, 20, "R1"); peek(25, 100, "R1"); peek(24, 0, "R1");
      check("R1", int'(irq), 0, "irq after reset");

      // R2 wrong flag code and missing tick
      load_cmd('h11, 'hD1, 2, 50, 'h81);
      cyc(0, 0, 0, 1); idle(2);
      peek(8, 0, "R2"); peek(11, 0, "R2");
      wr(0, 'h80); idle(4);
      peek(8, 0, "R2");

      // R7 / R9 normal set, echo of ID and code
      run_full();
      expect_rsp(0, 2, 50, "R7");
      peek(9, 'h11, "R9"); peek(10, 'hD1, "R9");
      peek(17, 2, "R7"); peek(19, 50, "R7");

      // R6 zero removes the cap
      set_cap(0, 100, 0, "R6");
      // R7 clamping corners
      set_cap(5, 10, 2, "R7");
      set_cap(10, 10, 2, "R7");
      set_cap(100, 100, 2, "R7");
      set_cap(101, 100, 2, "R7");
      set_cap(37, 37, 2, "R7");
      // R10 argument bytes 01,00 mean 256, clamped to 100
      set_cap(256, 100, 2, "R10");
      set_cap(9, 10, 2, "R7");

      // R5 bad length: current cap (10) returned, cap unchanged
      wr(8, 0);
      load_cmd('h31, 'hD1, 3, 55, 'h80);
      run_full();
      expect_rsp('h12, 2, 10, "R5");
      peek(19, 10, "R5"); peek(17, 2, "R5");

      // R10 length bytes 02,00 = 512, not 2
      wr(8, 0);
      load_cmd('h32, 'hD1, 512, 60, 'h80);
      run_full();
      expect_rsp('h12, 2, 10, "R10");

      // R8 unknown command
      wr(8, 0);
      load_cmd('h42, 'h42, 2, 60, 'h80);
      run_full();
      expect_rsp('h11, 0, 0, "R8");
      peek(10, 'h42, "R8"); peek(19, 10, "R8");

      // R4 response flag left at 0x01: immediate fault completion
      load_cmd('h55, 'hD1, 2, 70, 'h80);
      cyc(0, 0, 0, 1);
      idle(1);
      expect_rsp('h15, 0, 0, "R4");
      peek(8, 'h01, "R4"); peek(9, 'h55, "R4"); peek(19, 10, "R4");
      idle(1);
      peek(0, 0, "R4");
      check("R4", int'(irq), 1, "irq on fault completion");
      idle(1);

      // R11 read-only writes ignored
      wr(19, 7); wr(11, 'h55); wr(16, 0); wr(25, 1);
      idle(1);
      peek(19, 10, "R11"); peek(11, 'h15, "R11");
      peek(16, 3, "R11"); peek(25, 100, "R11");

      // R11 engine wins over host write to the response flag on busy step
      wr(8, 0);
      load_cmd('h66, 'hD1, 2, 80, 'h80);
      cyc(1, 8, 'h07, 1);
      idle(1);
      peek(8, 'h02, "R11");
      idle(4);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule